// File: doc/BRIEF.md
# Single-Cycle Sixteen-Bit Harvard Processor

This block is a small processor that fetches one 16-bit instruction and completes it in the same clock cycle. Program and data live in two separate internal arrays, so a fetch and a data access never compete for a port. Eight 16-bit registers feed two operand buses: bus A and bus B. A function unit combines them and holds a one-bit shifter on bus B. A decoder turns the opcode into control bits, and a next-address unit moves the program counter by counting, by a signed branch offset or by a jump through a register.

The core has two states. In `ST_LOAD` it is held: the program counter stays at word 0, no instruction writes anything, and the load port can fill either memory. Transition LOAD→RUN happens on the first clock edge where `load_mode` is low; instruction word 0 then executes in the following cycle. Transition RUN→LOAD happens on any edge where `load_mode` is high, and the program counter returns to 0. Each executing cycle shows its register or memory write on a set of trace ports, so a surrounding environment can follow the program's effect without reaching inside.

Instruction fields: opcode in bits 15..9, destination register in 8..6, source A in 5..3, source B or 3-bit immediate in 2..0. A branch offset is the six bits {8..6, 2..0}, read as two's complement.

Top module: `sc16_core`

## Requirements
- R1: An active-low asynchronous reset clears all eight registers and the program counter, and puts the core in `ST_LOAD`, with both write strobes low.
- R2: While the core is in `ST_LOAD`, it makes no register or data-memory write and holds `pc` at 0. With `load_mode` high, the load port writes `load_data` at `load_addr` on each edge where `load_we` is high: into instruction memory when `load_imem`=1, otherwise into data memory. After the first edge with `load_mode` low, word 0 executes.
- R3: Bits 15..13 set the instruction class: 000 register operation, 001 load, 010 store, 100 operation with immediate, 110 conditional branch, 111 jump. Classes 011 and 101 do nothing. In the immediate class, bits 2..0 are zero-extended to 16 bits and replace bus B (LDI 1001100, ADI 1000010).
- R4: A load (0010000) writes data memory at address R[SA] into R[DR]. A store (0100000) writes R[SB] to data memory at R[SA]. The data address uses the low DMEM_AW bits of bus A, and a load sees a store made in an earlier cycle.
- R5: For classes 000 and 100, opcode bits 12..9 select the operation: 0000 pass A, 0001 A+1, 0010 A+B, 0101 A-B, 0110 A-1, 1000 AND, 1001 OR, 1010 XOR, 1011 NOT A, 1100 pass B. The result is written to R[DR].
- R6: Codes 1101 and 1110 shift bus B right and left by one place, with a zero shifted in. Bus B is R[SB], not R[SA].
- R7: All arithmetic wraps modulo 2^16.
- R8: Every instruction outside classes 110 and 111 advances `pc` by exactly 1.
- R9: A jump (1110000) loads `pc` with R[SA].
- R10: Opcode 1100000 branches when R[SA] is zero; opcode 1100001 branches when bit 15 of R[SA] is set. A taken branch adds the sign-extended 6-bit offset to `pc`, and an untaken branch adds 1.
- R11: During each executing cycle, the trace ports show the instruction's register write (`rf_we`, `rf_wa`, `rf_wd`) or data write (`dm_we`, `dm_addr` = full bus A, `dm_wd`). The write takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_mode | input | 1 | 1 holds the core in the load state |
| load_we | input | 1 | Load port write strobe |
| load_imem | input | 1 | 1 selects instruction memory, 0 data memory |
| load_addr | input | LD_AW | Load port word address |
| load_data | input | 16 | Load port write data |
| pc | output | 16 | Program counter |
| rf_we | output | 1 | Register write of the current instruction |
| rf_wa | output | 3 | Destination register index |
| rf_wd | output | 16 | Value written to the register |
| dm_we | output | 1 | Data memory write of the current instruction |
| dm_addr | output | 16 | Data address (bus A) |
| dm_wd | output | 16 | Data written to memory (bus B) |

## Verification
On every cycle, the assertions check several rules: the program counter is held at zero in the load state; it steps by one after any non-transfer instruction and lands on R[SA] after a jump; a branch whose operand is neither zero nor negative falls through; a load-immediate writes only its three-bit constant; and a load right after a store to the same address returns the stored word. Only the bench's programs can show that every opcode computes the right value, that both branch kinds take the right path in both directions, and that memory addresses wrap. They also show the exact order and count of writes, because a wrongly taken branch runs filler instructions whose writes the scoreboard rejects.

// File: rtl/sc16_pkg.sv
package sc16_pkg;
    localparam int WORD_W = 16;
    localparam int REG_AW = 3;
    localparam int FS_W   = 4;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } core_state_e;

    typedef enum logic [2:0] {
        CL_ALU    = 3'b000,
        CL_LOAD   = 3'b001,
        CL_STORE  = 3'b010,
        CL_IMM    = 3'b100,
        CL_BRANCH = 3'b110,
        CL_JUMP   = 3'b111
    } instr_class_e;

    localparam logic [FS_W-1:0] FS_PASS_A = 4'b0000;
    localparam logic [FS_W-1:0] FS_INC    = 4'b0001;
    localparam logic [FS_W-1:0] FS_ADD    = 4'b0010;
    localparam logic [FS_W-1:0] FS_SUB    = 4'b0101;
    localparam logic [FS_W-1:0] FS_DEC    = 4'b0110;
    localparam logic [FS_W-1:0] FS_AND    = 4'b1000;
    localparam logic [FS_W-1:0] FS_OR     = 4'b1001;
    localparam logic [FS_W-1:0] FS_XOR    = 4'b1010;
    localparam logic [FS_W-1:0] FS_NOT    = 4'b1011;
    localparam logic [FS_W-1:0] FS_PASS_B = 4'b1100;
    localparam logic [FS_W-1:0] FS_SHR    = 4'b1101;
    localparam logic [FS_W-1:0] FS_SHL    = 4'b1110;

    typedef struct packed {
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] src_a;
        logic [REG_AW-1:0] src_b;
        logic [FS_W-1:0]   fsel;
        logic              use_const;
        logic              sel_mem;
        logic              reg_wr;
        logic              mem_wr;
        logic              pc_xfer;
        logic              is_jump;
        logic              on_neg;
    } ctrl_t;
endpackage

// File: rtl/sc16_regfile.sv
module sc16_regfile #(
    parameter int W  = 16,
    parameter int AW = 3,
    localparam int NREG = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb
);
    logic [W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && (wa == AW'(i))) begin
                regs[i] <= wd;
            end
        end
    end

    assign qa = regs[ra];
    assign qb = regs[rb];
endmodule

// File: rtl/sc16_func_unit.sv
module sc16_func_unit
    import sc16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [FS_W-1:0] fsel,
    output logic [W-1:0]    f,
    output logic            zero,
    output logic            neg
);
    always_comb begin
        case (fsel)
            FS_PASS_A: f = a;
            FS_INC:    f = a + W'(1);
            FS_ADD:    f = a + b;
            FS_SUB:    f = a + ~b + W'(1);
            FS_DEC:    f = a - W'(1);
            FS_AND:    f = a & b;
            FS_OR:     f = a | b;
            FS_XOR:    f = a ^ b;
            FS_NOT:    f = ~a;
            FS_PASS_B: f = b;
            FS_SHR:    f = {1'b0, b[W-1:1]};
            FS_SHL:    f = {b[W-2:0], 1'b0};
            default:   f = '0;
        endcase
    end

    assign zero = (f == '0);
    assign neg  = f[W-1];
endmodule

// File: rtl/sc16_decoder.sv
module sc16_decoder
    import sc16_pkg::*;
(
    input  logic [WORD_W-1:0] ir,
    output ctrl_t             ctl
);
    always_comb begin
        ctl           = '0;
        ctl.dst       = ir[8:6];
        ctl.src_a     = ir[5:3];
        ctl.src_b     = ir[2:0];
        ctl.fsel      = ir[12:9];
        ctl.on_neg    = ir[9];
        case (ir[15:13])
            CL_ALU: begin
                ctl.reg_wr = 1'b1;
            end
            CL_LOAD: begin
                ctl.reg_wr  = 1'b1;
                ctl.sel_mem = 1'b1;
            end
            CL_STORE: begin
                ctl.mem_wr = 1'b1;
            end
            CL_IMM: begin
                ctl.reg_wr    = 1'b1;
                ctl.use_const = 1'b1;
            end
            CL_BRANCH: begin
                ctl.pc_xfer = 1'b1;
                ctl.fsel    = FS_PASS_A;
            end
            CL_JUMP: begin
                ctl.pc_xfer = 1'b1;
                ctl.is_jump = 1'b1;
                ctl.fsel    = FS_PASS_A;
            end
            default: begin
                ctl.fsel = FS_PASS_A;
            end
        endcase
    end
endmodule

// File: rtl/sc16_pc_ctrl.sv
module sc16_pc_ctrl #(
    parameter int W     = 16,
    parameter int OFF_W = 6
) (
    input  logic [W-1:0]     pc,
    input  logic             pc_xfer,
    input  logic             is_jump,
    input  logic             on_neg,
    input  logic             zero,
    input  logic             neg,
    input  logic [OFF_W-1:0] offset,
    input  logic [W-1:0]     jump_addr,
    output logic [W-1:0]     pc_next
);
    logic [W-1:0] off_ext;
    logic         take;

    assign off_ext = {{(W-OFF_W){offset[OFF_W-1]}}, offset};
    assign take    = on_neg ? neg : zero;

    always_comb begin
        if (!pc_xfer) begin
            pc_next = pc + W'(1);
        end else if (is_jump) begin
            pc_next = jump_addr;
        end else if (take) begin
            pc_next = pc + off_ext;
        end else begin
            pc_next = pc + W'(1);
        end
    end
endmodule

// File: rtl/sc16_core.sv
module sc16_core
    import sc16_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    localparam int LD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_mode,
    input  logic              load_we,
    input  logic              load_imem,
    input  logic [LD_AW-1:0]  load_addr,
    input  logic [WORD_W-1:0] load_data,
    output logic [WORD_W-1:0] pc,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_wa,
    output logic [WORD_W-1:0] rf_wd,
    output logic              dm_we,
    output logic [WORD_W-1:0] dm_addr,
    output logic [WORD_W-1:0] dm_wd
);
    localparam int IMEM_DEPTH = 1 << IMEM_AW;
    localparam int DMEM_DEPTH = 1 << DMEM_AW;

    core_state_e       state, state_nxt;
    logic              running;
    logic [WORD_W-1:0] instr;
    ctrl_t             ctl;
    logic [WORD_W-1:0] reg_a, reg_b, bus_a, bus_b, bus_d;
    logic [WORD_W-1:0] const_zf, fu_out, dm_rdata, pc_next;
    logic              fu_zero, fu_neg;

    logic [WORD_W-1:0] imem [IMEM_DEPTH];
    logic [WORD_W-1:0] dmem [DMEM_DEPTH];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOAD;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        unique case (state)
            ST_LOAD: state_nxt = load_mode ? ST_LOAD : ST_RUN;
            ST_RUN:  state_nxt = load_mode ? ST_LOAD : ST_RUN;
            default: state_nxt = ST_LOAD;
        endcase
    end

    // state outputs
    always_comb begin
        running = 1'b0;
        unique case (state)
            ST_LOAD: running = 1'b0;
            ST_RUN:  running = 1'b1;
            default: running = 1'b0;
        endcase
        rf_we = running & ctl.reg_wr;
        dm_we = running & ctl.mem_wr;
    end

    // program counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (!running) begin
            pc <= '0;
        end else begin
            pc <= pc_next;
        end
    end

    // memories
    always_ff @(posedge clk) begin
        if (load_mode && load_we && load_imem) begin
            imem[load_addr[IMEM_AW-1:0]] <= load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (dm_we) begin
            dmem[bus_a[DMEM_AW-1:0]] <= bus_b;
        end else if (load_mode && load_we && !load_imem) begin
            dmem[load_addr[DMEM_AW-1:0]] <= load_data;
        end
    end

    assign instr    = imem[pc[IMEM_AW-1:0]];
    assign dm_rdata = dmem[bus_a[DMEM_AW-1:0]];

    sc16_decoder u_dec (
        .ir  (instr),
        .ctl (ctl)
    );

    sc16_regfile #(.W(WORD_W), .AW(REG_AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wa    (ctl.dst),
        .wd    (bus_d),
        .ra    (ctl.src_a),
        .rb    (ctl.src_b),
        .qa    (reg_a),
        .qb    (reg_b)
    );

    assign const_zf = {{(WORD_W-3){1'b0}}, instr[2:0]};
    assign bus_a    = reg_a;
    assign bus_b    = ctl.use_const ? const_zf : reg_b;

    sc16_func_unit #(.W(WORD_W)) u_fu (
        .a    (bus_a),
        .b    (bus_b),
        .fsel (ctl.fsel),
        .f    (fu_out),
        .zero (fu_zero),
        .neg  (fu_neg)
    );

    assign bus_d = ctl.sel_mem ? dm_rdata : fu_out;

    sc16_pc_ctrl #(.W(WORD_W), .OFF_W(6)) u_pcc (
        .pc        (pc),
        .pc_xfer   (ctl.pc_xfer),
        .is_jump   (ctl.is_jump),
        .on_neg    (ctl.on_neg),
        .zero      (fu_zero),
        .neg       (fu_neg),
        .offset    ({instr[8:6], instr[2:0]}),
        .jump_addr (bus_a),
        .pc_next   (pc_next)
    );

    assign rf_wa   = ctl.dst;
    assign rf_wd   = bus_d;
    assign dm_addr = bus_a;
    assign dm_wd   = bus_b;
endmodule

// File: rtl/sc16_checker.sv
module sc16_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         running,
    input logic [W-1:0] pc,
    input logic [W-1:0] instr,
    input logic [W-1:0] bus_a,
    input logic         rf_we,
    input logic [W-1:0] rf_wd,
    input logic         dm_we,
    input logic [W-1:0] dm_addr,
    input logic [W-1:0] dm_wd
);
    logic xfer_op, jump_op, branch_op, ldi_op, ld_op;
    assign xfer_op   = (instr[15:14] == 2'b11);
    assign jump_op   = (instr[15:13] == 3'b111);
    assign branch_op = (instr[15:13] == 3'b110);
    assign ldi_op    = (instr[15:9] == 7'b1001100);
    assign ld_op     = (instr[15:13] == 3'b001);

    a_r2_load_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (pc == '0));

    a_r8_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !xfer_op) |=> (pc == $past(pc) + W'(1)));

    a_r9_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (running && jump_op) |=> (pc == $past(bus_a)));

    a_r10_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        (running && branch_op && (bus_a != '0) && !bus_a[W-1]) |=> (pc == $past(pc) + W'(1)));

    a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ldi_op) |-> (rf_we && (rf_wd == {{(W-3){1'b0}}, instr[2:0]})));

    a_r4_load_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ld_op && $past(dm_we) && (bus_a == $past(dm_addr))) |-> (rf_wd == $past(dm_wd)));
endmodule

bind sc16_core sc16_checker #(.W(16)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (running),
    .pc      (pc),
    .instr   (instr),
    .bus_a   (bus_a),
    .rf_we   (rf_we),
    .rf_wd   (rf_wd),
    .dm_we   (dm_we),
    .dm_addr (dm_addr),
    .dm_wd   (dm_wd)
);

// File: tb/sc16_core_test.sv
module sc16_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_mode = 1'b1;
    logic        load_we = 1'b0;
    logic        load_imem = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [15:0] load_data = '0;
    logic [15:0] pc;
    logic        rf_we, dm_we;
    logic [2:0]  rf_wa;
    logic [15:0] rf_wd, dm_addr, dm_wd;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 1'b0;
    bit  mon_on = 1'b0;

    typedef struct {
        bit          is_mem;
        logic [15:0] addr;
        logic [15:0] data;
        string       req;
    } exp_t;
    exp_t q[$];

    localparam logic [6:0] OP_MOVA = 7'b0000000, OP_INC = 7'b0000001, OP_ADD = 7'b0000010,
                           OP_SUB = 7'b0000101, OP_DEC = 7'b0000110, OP_AND = 7'b0001000,
                           OP_OR = 7'b0001001, OP_XOR = 7'b0001010, OP_NOT = 7'b0001011,
                           OP_MOVB = 7'b0001100, OP_SHR = 7'b0001101, OP_SHL = 7'b0001110,
                           OP_LDI = 7'b1001100, OP_ADI = 7'b1000010, OP_LD = 7'b0010000,
                           OP_ST = 7'b0100000, OP_BRZ = 7'b1100000, OP_BRN = 7'b1100001,
                           OP_JMP = 7'b1110000;

    sc16_core uut (
        .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .load_we(load_we),
        .load_imem(load_imem), .load_addr(load_addr), .load_data(load_data),
        .pc(pc), .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd),
        .dm_we(dm_we), .dm_addr(dm_addr), .dm_wd(dm_wd)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] enc(input logic [6:0] op, input int dr, input int sa, input int sb);
        return {op, 3'(dr), 3'(sa), 3'(sb)};
    endfunction

    function automatic logic [15:0] encb(input logic [6:0] op, input int sa, input int off);
        logic [5:0] ad;
        ad = 6'(off);
        return {op, ad[5:3], 3'(sa), ad[2:0]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input bit imem, input int addr, input logic [15:0] w);
        @(negedge clk);
        load_imem = imem;
        load_addr = 6'(addr);
        load_data = w;
        load_we   = 1'b1;
        @(negedge clk);
        load_we   = 1'b0;
    endtask

    task automatic exp_reg(input int r, input logic [15:0] d, input string req);
        exp_t e;
        e.is_mem = 1'b0; e.addr = 16'(r); e.data = d; e.req = req;
        q.push_back(e);
    endtask

    task automatic exp_mem(input logic [15:0] a, input logic [15:0] d, input string req);
        exp_t e;
        e.is_mem = 1'b1; e.addr = a; e.data = d; e.req = req;
        q.push_back(e);
    endtask

    // monitor: pops the scoreboard on each observed write
    always @(negedge clk) begin
        if (mon_on && (rf_we || dm_we)) begin
            if (q.size() == 0) begin
                n_checks++;
                n_err++;
                $display("FAIL R11 unexpected write at pc %h actual %h expected none", pc, rf_we ? rf_wd : dm_wd);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.req, " kind"}, {15'b0, dm_we}, {15'b0, e.is_mem});
                check({e.req, " addr"}, dm_we ? dm_addr : {13'b0, rf_wa}, e.addr);
                check({e.req, " data"}, dm_we ? dm_wd : rf_wd, e.data);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] filler;
        filler = enc(OP_INC, 7, 7, 0);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pc", pc, 16'h0000);
        check("R1 rf_we", {15'b0, rf_we}, 16'h0);
        check("R1 dm_we", {15'b0, dm_we}, 16'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        for (int i = 0; i < 64; i++) put(1'b1, i, filler);
        put(1'b0, 1, 16'hA5A5);
        put(1'b1, 0,  enc(OP_INC, 1, 0, 0));
        put(1'b1, 1,  enc(OP_INC, 2, 1, 0));
        put(1'b1, 2,  enc(OP_ADI, 3, 2, 7));
        put(1'b1, 3,  enc(OP_ADD, 4, 3, 2));
        put(1'b1, 4,  enc(OP_SUB, 5, 2, 3));
        put(1'b1, 5,  enc(OP_DEC, 6, 1, 0));
        put(1'b1, 6,  enc(OP_AND, 7, 3, 4));
        put(1'b1, 7,  enc(OP_OR, 7, 3, 5));
        put(1'b1, 8,  enc(OP_XOR, 7, 3, 4));
        put(1'b1, 9,  enc(OP_NOT, 7, 3, 0));
        put(1'b1, 10, enc(OP_MOVA, 7, 5, 0));
        put(1'b1, 11, enc(OP_MOVB, 7, 0, 4));
        put(1'b1, 12, enc(OP_SHR, 7, 0, 5));
        put(1'b1, 13, enc(OP_SHL, 7, 0, 5));
        put(1'b1, 14, enc(OP_LDI, 7, 0, 5));
        put(1'b1, 15, enc(OP_ST, 0, 3, 4));
        put(1'b1, 16, enc(OP_LD, 7, 3, 0));
        put(1'b1, 17, enc(OP_LD, 7, 1, 0));
        put(1'b1, 18, encb(OP_BRZ, 6, 3));
        put(1'b1, 21, encb(OP_BRN, 5, 2));
        put(1'b1, 23, encb(OP_BRZ, 1, 5));
        put(1'b1, 24, encb(OP_BRN, 2, 5));
        put(1'b1, 25, enc(OP_SUB, 1, 2, 3));
        put(1'b1, 26, enc(OP_ADI, 6, 3, 7));
        put(1'b1, 27, enc(OP_SHL, 6, 0, 6));
        put(1'b1, 28, enc(OP_JMP, 0, 6, 0));
        put(1'b1, 32, enc(OP_LDI, 4, 0, 3));
        put(1'b1, 33, enc(OP_NOT, 5, 0, 0));
        put(1'b1, 34, encb(OP_BRZ, 0, 1));
        put(1'b1, 35, enc(OP_ST, 0, 4, 5));
        put(1'b1, 36, enc(OP_LD, 7, 4, 0));
        put(1'b1, 37, encb(OP_BRZ, 0, 8));
        put(1'b1, 45, enc(OP_ADI, 2, 7, 3));
        put(1'b1, 46, encb(OP_BRZ, 0, 9));
        put(1'b1, 50, encb(OP_BRZ, 0, 0));
        put(1'b1, 55, encb(OP_BRZ, 6, 44));
        put(1'b1, 56, enc(OP_LDI, 6, 0, 0));
        put(1'b1, 57, encb(OP_BRZ, 6, -7));
        // R2 held while loading
        check("R2 pc held", pc, 16'h0000);

        exp_reg(1, 16'h0001, "R5 inc");
        exp_reg(2, 16'h0002, "R5 inc");
        exp_reg(3, 16'h0009, "R3 adi");
        exp_reg(4, 16'h000B, "R5 add");
        exp_reg(5, 16'hFFF9, "R7 sub wrap");
        exp_reg(6, 16'h0000, "R5 dec");
        exp_reg(7, 16'h0009, "R5 and");
        exp_reg(7, 16'hFFF9, "R5 or");
        exp_reg(7, 16'h0002, "R5 xor");
        exp_reg(7, 16'hFFF6, "R5 not");
        exp_reg(7, 16'hFFF9, "R5 pass a");
        exp_reg(7, 16'h000B, "R5 pass b");
        exp_reg(7, 16'h7FFC, "R6 shr");
        exp_reg(7, 16'hFFF2, "R6 shl");
        exp_reg(7, 16'h0005, "R3 ldi");
        exp_mem(16'h0009, 16'h000B, "R4 store");
        exp_reg(7, 16'h000B, "R4 load after store");
        exp_reg(7, 16'hA5A5, "R4 load preloaded");
        exp_reg(1, 16'hFFF9, "R10 brz/brn paths");
        exp_reg(6, 16'h0010, "R3 adi");
        exp_reg(6, 16'h0020, "R6 shl");
        exp_reg(4, 16'h0003, "R9 jump target");
        exp_reg(5, 16'hFFFF, "R5 not");
        exp_mem(16'h0003, 16'hFFFF, "R4 store");
        exp_reg(7, 16'hFFFF, "R4 load");
        exp_reg(2, 16'h0002, "R7 adi wrap");
        exp_reg(6, 16'h0000, "R10 negative offset fall");

        @(negedge clk);
        load_mode = 1'b0;
        repeat (70) @(negedge clk);
        check("R10 halt pc", pc, 16'd50);
        check("R11 all writes seen", 16'(q.size()), 16'h0);

        // RUN -> LOAD
        load_mode = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 pc cleared", pc, 16'h0000);

        put(1'b1, 0,  enc(OP_INC, 1, 5, 0));
        put(1'b1, 1,  encb(OP_BRZ, 1, 2));
        put(1'b1, 2,  filler);
        put(1'b1, 3,  enc(OP_SHL, 2, 0, 5));
        put(1'b1, 4,  enc(OP_SHR, 3, 0, 5));
        put(1'b1, 5,  encb(OP_BRN, 3, 2));
        put(1'b1, 6,  encb(OP_BRN, 2, 2));
        put(1'b1, 7,  filler);
        put(1'b1, 8,  enc(OP_DEC, 4, 0, 0));
        put(1'b1, 9,  enc(OP_ST, 0, 5, 3));
        put(1'b1, 10, encb(OP_BRZ, 0, 0));

        exp_reg(1, 16'h0000, "R7 inc wrap");
        exp_reg(2, 16'hFFFE, "R6 shl zero fill");
        exp_reg(3, 16'h7FFF, "R6 shr zero fill");
        exp_reg(4, 16'hFFFF, "R7 dec wrap");
        exp_mem(16'hFFFF, 16'h7FFF, "R4 store high address");

        @(negedge clk);
        load_mode = 1'b0;
        repeat (20) @(negedge clk);
        check("R8 halt pc", pc, 16'd10);
        check("R11 all writes seen", 16'(q.size()), 16'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule